// File: doc/BRIEF.md
# Sound Memory DMA Engine

This block moves 16-bit words between a host word stream and a word-addressed sound memory with a 20-bit address. A transfer has a direction, a length and a start address. Memory-to-host transfers read one word at a time through a synchronous single-port memory port and offer each word on a valid/ready output stream. Host-to-memory transfers take words from a valid/ready input stream and write them to memory. A transfer address register sits on a small register port. It advances as the transfer runs. When the transfer finishes it gets a direction-specific adjustment.

Both directions watch a programmable interrupt address. Memory-to-host transfers compare every word address with it. Host-to-memory transfers test a window just past the final address. A hit latches a sticky flag when the interrupt-enable control bit is set. A ready bit in the status register is cleared when a transfer starts. It is set again by an external completion strobe, and the same strobe clears a two-bit mode field in the control register. Every finished transfer pulses a done output and sets a sticky completion flag.

Top module: `snd_dma_engine`

## Requirements
- R1: After reset the transfer address, the interrupt address and the control register read 0, the status register reads 0x80 (ready bit 7 set, flags clear), and busy is low.
- R2: A memory-to-host transfer (dir 0) of N words reads addresses A, A+1, ... in order and presents each word on the host output stream in that order; the address wraps from 0xFFFFF to 0.
- R3: When a memory-to-host transfer ends, the transfer address (register 0) reads (A + N + 19) mod 2^20.
- R4: In a memory-to-host transfer, if control bit 6 is set and a word address equals the interrupt address (register 1), status bit 2 is set; with bit 6 clear it stays clear.
- R5: A host-to-memory transfer (dir 1) of N words writes the accepted host words in order to addresses A, A+1, ... (mod 2^20), and the transfer address then reads A + N.
- R6: After a host-to-memory transfer, if A + N (computed without wrapping) exceeds 0xFFFFE, the transfer address is reloaded with 0x2800 instead.
- R7: After a host-to-memory transfer with control bit 6 set, status bit 2 is set exactly when A + N < interrupt address <= A + N + 0x20.
- R8: Status bit 7 is cleared when a transfer starts. A pulse on dma_done_i sets it and clears control bits 5:4, leaving the other control bits as written.
- R9: Every finished transfer pulses xfer_done_o for one cycle and sets status bit 1.
- R10: Writing 1 to status bit 1 or bit 2 (register 3) clears that bit. Writing 0 leaves it unchanged.
- R11: A start request with a length of 0, or one made while busy, is ignored: no memory access, no address change, no done pulse.
- R12: The output stream holds valid and data stable until ready is seen. Host-to-memory transfers write only on cycles where the input stream is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 transfer address, 1 interrupt address, 2 control, 3 status |
| reg_wdata_i | input | 20 | Register write data |
| reg_rdata_o | output | 20 | Register read data for reg_addr_i (combinational) |
| xfer_start_i | input | 1 | Transfer start request |
| xfer_dir_i | input | 1 | 0 memory-to-host, 1 host-to-memory |
| xfer_len_i | input | 16 | Transfer length in words |
| dma_done_i | input | 1 | External completion strobe |
| hout_valid_o | output | 1 | Output stream word valid |
| hout_ready_i | input | 1 | Output stream ready |
| hout_data_o | output | 16 | Output stream word |
| hin_valid_i | input | 1 | Input stream word valid |
| hin_ready_o | output | 1 | Input stream ready |
| hin_data_i | input | 16 | Input stream word |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 20 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after the access |
| busy_o | output | 1 | Transfer in progress |
| xfer_done_o | output | 1 | One-cycle transfer-finished pulse |
| addr_irq_o | output | 1 | Interrupt-address hit flag (status bit 2) |
| cmpl_irq_o | output | 1 | Completion flag (status bit 1) |

## Verification
The bench reads across the top of the address space. A design that saturates at 0xFFFFF or wraps the read pointer to the reload value would send the wrong words and leave the wrong final address. The write window is probed at its two edges and just past each of them. An off-by-one in either comparison would set or miss the interrupt flag. Writes that end exactly at 0xFFFFE and one word past it separate a wrong reload threshold from the right one. Start requests of zero length, and requests made while an output word is stalled, are checked to cause no writes, no extra done pulse and no address change.

// File: rtl/snd_dma_pkg.sv
package snd_dma_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_ISSUE,
    S_RD_WAIT,
    S_RD_HOLD,
    S_WR_DATA,
    S_FIN
  } seq_state_e;

  localparam logic [1:0] RA_XADDR = 2'd0;
  localparam logic [1:0] RA_IRQA  = 2'd1;
  localparam logic [1:0] RA_CTRL  = 2'd2;
  localparam logic [1:0] RA_STAT  = 2'd3;

  localparam int CTRL_IRQEN_BIT = 6;
  localparam int CTRL_MODE_LO   = 4;
  localparam int CTRL_MODE_HI   = 5;
  localparam int STAT_RDY_BIT   = 7;
  localparam int STAT_HIT_BIT   = 2;
  localparam int STAT_CMPL_BIT  = 1;

endpackage

// File: rtl/snd_dma_irqcmp.sv
module snd_dma_irqcmp #(
  parameter int AW  = 20,
  parameter int WIN = 32
) (
  input  logic          en_i,
  input  logic [AW-1:0] word_addr_i,
  input  logic [AW:0]   end_addr_i,
  input  logic [AW-1:0] irqa_i,
  output logic          rd_hit_o,
  output logic          wr_hit_o
);

  localparam logic [AW+1:0] WIN_V = (AW+2)'(WIN);

  logic [AW+1:0] irqa_x;
  logic [AW+1:0] end_x;

  always_comb begin
    irqa_x   = {2'b00, irqa_i};
    end_x    = {1'b0, end_addr_i};
    rd_hit_o = en_i && (word_addr_i == irqa_i);
    wr_hit_o = en_i && (irqa_x > end_x) && (irqa_x <= end_x + WIN_V);
  end

endmodule

// File: rtl/snd_dma_regs.sv
module snd_dma_regs
  import snd_dma_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [1:0]    waddr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          hit_i,
  input  logic          cmpl_i,
  input  logic          start_evt_i,
  input  logic          dma_done_i,
  output logic [AW-1:0] irqa_o,
  output logic [CW-1:0] ctrl_o,
  output logic [CW-1:0] stat_o
);

  logic [AW-1:0] irqa_q, irqa_d;
  logic [CW-1:0] ctrl_q, ctrl_d;
  logic          rdy_q, rdy_d;
  logic          hit_q, hit_d;
  logic          cmpl_q, cmpl_d;
  logic          irqa_en, ctrl_en, stat_wr;

  always_comb begin
    irqa_en = (wr_i && waddr_i == RA_IRQA);
    ctrl_en = (wr_i && waddr_i == RA_CTRL) || dma_done_i;
    stat_wr = wr_i && waddr_i == RA_STAT;

    irqa_d = wdata_i;

    ctrl_d = ctrl_q;
    if (wr_i && waddr_i == RA_CTRL) ctrl_d = wdata_i[CW-1:0];
    if (dma_done_i) ctrl_d[CTRL_MODE_HI:CTRL_MODE_LO] = '0;

    rdy_d = rdy_q;
    if (start_evt_i)     rdy_d = 1'b0;
    else if (dma_done_i) rdy_d = 1'b1;

    hit_d = hit_q;
    if (hit_i)                                hit_d = 1'b1;
    else if (stat_wr && wdata_i[STAT_HIT_BIT]) hit_d = 1'b0;

    cmpl_d = cmpl_q;
    if (cmpl_i)                                 cmpl_d = 1'b1;
    else if (stat_wr && wdata_i[STAT_CMPL_BIT]) cmpl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqa_q <= '0;
      ctrl_q <= '0;
      rdy_q  <= 1'b1;
      hit_q  <= 1'b0;
      cmpl_q <= 1'b0;
    end else begin
      if (irqa_en) irqa_q <= irqa_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
      rdy_q  <= rdy_d;
      hit_q  <= hit_d;
      cmpl_q <= cmpl_d;
    end
  end

  always_comb begin
    stat_o                = '0;
    stat_o[STAT_RDY_BIT]  = rdy_q;
    stat_o[STAT_HIT_BIT]  = hit_q;
    stat_o[STAT_CMPL_BIT] = cmpl_q;
  end

  assign irqa_o = irqa_q;
  assign ctrl_o = ctrl_q;

endmodule

// File: rtl/snd_dma_seq.sv
module snd_dma_seq
  import snd_dma_pkg::*;
#(
  parameter int          AW        = 20,
  parameter int          DW        = 16,
  parameter int          LW        = 16,
  parameter int          RD_TAIL   = 19,
  parameter logic [AW-1:0] WR_LIMIT  = 20'hFFFFE,
  parameter logic [AW-1:0] WR_RELOAD = 20'h02800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          dir_i,
  input  logic [LW-1:0] len_i,
  input  logic          addr_wr_i,
  input  logic [AW-1:0] addr_wdata_i,
  output logic          hout_valid_o,
  input  logic          hout_ready_i,
  output logic [DW-1:0] hout_data_o,
  input  logic          hin_valid_i,
  output logic          hin_ready_o,
  input  logic [DW-1:0] hin_data_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW:0]   end_addr_o,
  output logic          rd_chk_o,
  output logic          wr_fin_o,
  output logic          done_o,
  output logic          start_evt_o,
  output logic          busy_o
);

  localparam logic [AW-1:0] TAIL_V  = AW'(RD_TAIL);
  localparam logic [AW:0]   LIMIT_X = {1'b0, WR_LIMIT};
  localparam logic [LW-1:0] ONE_L   = LW'(1);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [AW:0]   wcnt_q, wcnt_d;
  logic [LW-1:0] rem_q, rem_d;
  logic          dir_q, dir_d;
  logic [DW-1:0] dat_q;
  logic          dat_en;

  always_comb begin
    state_d      = state_q;
    cur_d        = cur_q;
    wcnt_d       = wcnt_q;
    rem_d        = rem_q;
    dir_d        = dir_q;
    dat_en       = 1'b0;
    mem_en_o     = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = cur_q;
    mem_wdata_o  = hin_data_i;
    hout_valid_o = 1'b0;
    hin_ready_o  = 1'b0;
    rd_chk_o     = 1'b0;
    wr_fin_o     = 1'b0;
    done_o       = 1'b0;
    start_evt_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i && len_i != '0) begin
          start_evt_o = 1'b1;
          dir_d       = dir_i;
          rem_d       = len_i;
          wcnt_d      = {1'b0, cur_q};
          state_d     = dir_i ? S_WR_DATA : S_RD_ISSUE;
        end else if (addr_wr_i) begin
          cur_d = addr_wdata_i;
        end
      end
      S_RD_ISSUE: begin
        mem_en_o = 1'b1;
        rd_chk_o = 1'b1;
        cur_d    = cur_q + 1'b1;
        rem_d    = rem_q - ONE_L;
        state_d  = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        dat_en  = 1'b1;
        state_d = S_RD_HOLD;
      end
      S_RD_HOLD: begin
        hout_valid_o = 1'b1;
        if (hout_ready_i) state_d = (rem_q == '0) ? S_FIN : S_RD_ISSUE;
      end
      S_WR_DATA: begin
        hin_ready_o = 1'b1;
        mem_addr_o  = wcnt_q[AW-1:0];
        if (hin_valid_i) begin
          mem_en_o = 1'b1;
          mem_we_o = 1'b1;
          wcnt_d   = wcnt_q + 1'b1;
          rem_d    = rem_q - ONE_L;
          if (rem_q == ONE_L) state_d = S_FIN;
        end
      end
      S_FIN: begin
        done_o  = 1'b1;
        state_d = S_IDLE;
        if (dir_q) begin
          wr_fin_o = 1'b1;
          cur_d    = (wcnt_q > LIMIT_X) ? WR_RELOAD : wcnt_q[AW-1:0];
        end else begin
          cur_d = cur_q + TAIL_V;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cur_q   <= '0;
      wcnt_q  <= '0;
      rem_q   <= '0;
      dir_q   <= 1'b0;
      dat_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      wcnt_q  <= wcnt_d;
      rem_q   <= rem_d;
      dir_q   <= dir_d;
      if (dat_en) dat_q <= mem_rdata_i;
    end
  end

  assign hout_data_o = dat_q;
  assign cur_addr_o  = cur_q;
  assign end_addr_o  = wcnt_q;
  assign busy_o      = (state_q != S_IDLE);

endmodule

// File: rtl/snd_dma_engine.sv
module snd_dma_engine
  import snd_dma_pkg::*;
#(
  parameter int AW      = 20,
  parameter int DW      = 16,
  parameter int LW      = 16,
  parameter int CW      = 16,
  parameter int RD_TAIL = 19,
  parameter int WR_WIN  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          xfer_start_i,
  input  logic          xfer_dir_i,
  input  logic [LW-1:0] xfer_len_i,
  input  logic          dma_done_i,
  output logic          hout_valid_o,
  input  logic          hout_ready_i,
  output logic [DW-1:0] hout_data_o,
  input  logic          hin_valid_i,
  output logic          hin_ready_o,
  input  logic [DW-1:0] hin_data_i,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          xfer_done_o,
  output logic          addr_irq_o,
  output logic          cmpl_irq_o
);

  localparam int PAD = AW - CW;

  logic          rst_meta_q, rst_sync_n;
  logic [AW-1:0] cur_addr_w, irqa_w;
  logic [AW:0]   end_addr_w;
  logic [CW-1:0] ctrl_w, stat_w;
  logic          rd_chk, wr_fin, start_evt, done_w;
  logic          rd_hit, wr_hit, hit_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  snd_dma_seq #(
    .AW(AW), .DW(DW), .LW(LW), .RD_TAIL(RD_TAIL)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (xfer_start_i),
    .dir_i        (xfer_dir_i),
    .len_i        (xfer_len_i),
    .addr_wr_i    (reg_wr_i && reg_addr_i == RA_XADDR),
    .addr_wdata_i (reg_wdata_i),
    .hout_valid_o (hout_valid_o),
    .hout_ready_i (hout_ready_i),
    .hout_data_o  (hout_data_o),
    .hin_valid_i  (hin_valid_i),
    .hin_ready_o  (hin_ready_o),
    .hin_data_i   (hin_data_i),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i),
    .cur_addr_o   (cur_addr_w),
    .end_addr_o   (end_addr_w),
    .rd_chk_o     (rd_chk),
    .wr_fin_o     (wr_fin),
    .done_o       (done_w),
    .start_evt_o  (start_evt),
    .busy_o       (busy_o)
  );

  snd_dma_irqcmp #(.AW(AW), .WIN(WR_WIN)) cmp_i (
    .en_i        (ctrl_w[CTRL_IRQEN_BIT]),
    .word_addr_i (mem_addr_o),
    .end_addr_i  (end_addr_w),
    .irqa_i      (irqa_w),
    .rd_hit_o    (rd_hit),
    .wr_hit_o    (wr_hit)
  );

  assign hit_evt = (rd_chk && rd_hit) || (wr_fin && wr_hit);

  snd_dma_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_i        (reg_wr_i),
    .waddr_i     (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .hit_i       (hit_evt),
    .cmpl_i      (done_w),
    .start_evt_i (start_evt),
    .dma_done_i  (dma_done_i),
    .irqa_o      (irqa_w),
    .ctrl_o      (ctrl_w),
    .stat_o      (stat_w)
  );

  always_comb begin
    unique case (reg_addr_i)
      RA_XADDR: reg_rdata_o = cur_addr_w;
      RA_IRQA:  reg_rdata_o = irqa_w;
      RA_CTRL:  reg_rdata_o = {{PAD{1'b0}}, ctrl_w};
      default:  reg_rdata_o = {{PAD{1'b0}}, stat_w};
    endcase
  end

  assign xfer_done_o = done_w;
  assign addr_irq_o  = stat_w[STAT_HIT_BIT];
  assign cmpl_irq_o  = stat_w[STAT_CMPL_BIT];

endmodule

// File: rtl/snd_dma_chk.sv
module snd_dma_chk #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_done_i,
  input logic          start_evt,
  input logic [CW-1:0] ctrl_w,
  input logic [CW-1:0] stat_w,
  input logic [AW-1:0] irqa_w,
  input logic          hout_valid_o,
  input logic          hout_ready_i,
  input logic [DW-1:0] hout_data_o,
  input logic          hin_ready_o,
  input logic          mem_en_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          xfer_done_o,
  input logic          busy_o
);

  assert_rdy_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done_i && !start_evt) |=> stat_w[7]);

  assert_mode_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done_i |=> (ctrl_w[5:4] == 2'b00));

  assert_rdy_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !stat_w[7]);

  assert_cmpl_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> stat_w[1]);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !xfer_done_o);

  assert_rd_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o && ctrl_w[6] && mem_addr_o == irqa_w) |=> stat_w[2]);

  assert_out_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (hout_valid_o && !hout_ready_i) |=> (hout_valid_o && $stable(hout_data_o)));

  assert_mem_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_en_o && !hin_ready_o && !hout_valid_o));

  assert_we_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> mem_en_o);

endmodule

bind snd_dma_engine snd_dma_chk #(.AW(AW), .DW(DW), .CW(CW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .dma_done_i   (dma_done_i),
  .start_evt    (start_evt),
  .ctrl_w       (ctrl_w),
  .stat_w       (stat_w),
  .irqa_w       (irqa_w),
  .hout_valid_o (hout_valid_o),
  .hout_ready_i (hout_ready_i),
  .hout_data_o  (hout_data_o),
  .hin_ready_o  (hin_ready_o),
  .mem_en_o     (mem_en_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .xfer_done_o  (xfer_done_o),
  .busy_o       (busy_o)
);

// File: tb/snd_dma_engine_tb.sv
module snd_dma_engine_tb_top;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [19:0] reg_wdata;
  logic [19:0] reg_rdata;
  logic        xs, xdir;
  logic [15:0] xlen;
  logic        dma_done;
  logic        hout_valid, hout_ready;
  logic [15:0] hout_data;
  logic        hin_valid, hin_ready;
  logic [15:0] hin_data;
  logic        mem_en, mem_we;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        busy, xdone, addr_irq, cmpl_irq;

  int vectors = 0;
  int fails   = 0;
  int done_cnt = 0;
  int cycles  = 0;

  logic [15:0] mem_m [int];
  logic [15:0] exp_rd [$];
  logic [35:0] exp_wr [$];

  snd_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .xfer_start_i(xs), .xfer_dir_i(xdir), .xfer_len_i(xlen), .dma_done_i(dma_done),
    .hout_valid_o(hout_valid), .hout_ready_i(hout_ready), .hout_data_o(hout_data),
    .hin_valid_i(hin_valid), .hin_ready_o(hin_ready), .hin_data_i(hin_data),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .xfer_done_o(xdone), .addr_irq_o(addr_irq), .cmpl_irq_o(cmpl_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [15:0] peek(input logic [19:0] a);
    if (mem_m.exists(int'(a))) return mem_m[int'(a)];
    return a[15:0] ^ 16'hC3A5 ^ {a[19:16], 12'h000};
  endfunction

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  // behavioural memory and per-clock stream comparison
  always @(posedge clk) begin
    cycles++;
    if (mem_en) begin
      if (mem_we) begin
        if (exp_wr.size() == 0) check("R11 unexpected write", {mem_addr, mem_wdata}, 36'h0);
        else check("R5 write", {mem_addr, mem_wdata}, exp_wr.pop_front());
        mem_m[int'(mem_addr)] = mem_wdata;
      end else begin
        mem_rdata <= peek(mem_addr);
      end
    end
    if (hout_valid && hout_ready) begin
      if (exp_rd.size() == 0) check("R2 extra word", {20'h0, hout_data}, 36'hF_FFFF_FFFF);
      else check("R2 read word", {20'h0, hout_data}, {20'h0, exp_rd.pop_front()});
    end
    if (xdone) done_cnt++;
  end

  task automatic wr_reg(input logic [1:0] a, input logic [19:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [19:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [19:0] e);
    logic [19:0] v;
    rd_reg(a, v);
    check(req, {16'h0, v}, {16'h0, e});
  endtask

  task automatic pulse_start(input logic d, input logic [15:0] n);
    @(negedge clk); xs = 1'b1; xdir = d; xlen = n;
    @(negedge clk); xs = 1'b0;
  endtask

  task automatic run_read(input logic [19:0] a, input int n, input int gap, input string req);
    int d0;
    wr_reg(2'd0, a);
    for (int i = 0; i < n; i++) exp_rd.push_back(peek(a + 20'(i)));
    d0 = done_cnt;
    pulse_start(1'b0, 16'(n));
    for (int c = 0; busy; c++) begin
      hout_ready = ((c % gap) == 0);
      @(negedge clk);
    end
    hout_ready = 1'b0;
    check({req, " words left"}, 36'(exp_rd.size()), 36'h0);
    check("R9 one done pulse", 36'(done_cnt - d0), 36'h1);
  endtask

  task automatic run_write(input logic [19:0] a, input int n, input int gap, input logic [15:0] seed);
    int i = 0;
    int c = 0;
    int d0;
    logic acc;
    wr_reg(2'd0, a);
    for (int k = 0; k < n; k++) exp_wr.push_back({a + 20'(k), seed + 16'(k)});
    d0 = done_cnt;
    pulse_start(1'b1, 16'(n));
    while (i < n) begin
      @(negedge clk);
      hin_valid = ((c % gap) == 0);
      hin_data  = seed + 16'(i);
      acc = hin_valid && hin_ready;
      @(posedge clk);
      if (acc) i++;
      c++;
    end
    @(negedge clk); hin_valid = 1'b0;
    while (busy) @(negedge clk);
    check("R5 all writes seen", 36'(exp_wr.size()), 36'h0);
    check("R9 one done pulse", 36'(done_cnt - d0), 36'h1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    xs = 1'b0; xdir = 1'b0; xlen = '0; dma_done = 1'b0;
    hout_ready = 1'b0; hin_valid = 1'b0; hin_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    expect_reg("R1 addr", 2'd0, 20'h0);
    expect_reg("R1 irqa", 2'd1, 20'h0);
    expect_reg("R1 ctrl", 2'd2, 20'h0);
    expect_reg("R1 stat", 2'd3, 20'h80);
    check("R1 busy", {35'h0, busy}, 36'h0);

    // R2/R3 plain read with full-rate ready
    run_read(20'h01230, 6, 1, "R2");
    expect_reg("R3 end addr", 2'd0, 20'h01249);
    expect_reg("R9 R8 stat after read", 2'd3, 20'h02);

    // R10 W1C
    wr_reg(2'd3, 20'h00000);
    expect_reg("R10 write zero keeps", 2'd3, 20'h02);
    wr_reg(2'd3, 20'h00002);
    expect_reg("R10 clear cmpl", 2'd3, 20'h00);

    // R2 wrap with stalls (R12), R3 tail across wrap
    run_read(20'hFFFFE, 4, 3, "R2 wrap R12");
    expect_reg("R3 wrapped end", 2'd0, 20'h00015);

    // R4 read irq enabled / disabled
    wr_reg(2'd3, 20'h6);
    wr_reg(2'd2, 20'h40);
    wr_reg(2'd1, 20'h00502);
    run_read(20'h00500, 4, 1, "R4");
    expect_reg("R4 hit set", 2'd3, 20'h06);
    wr_reg(2'd3, 20'h6);
    wr_reg(2'd2, 20'h00);
    wr_reg(2'd1, 20'h00501);
    run_read(20'h00500, 4, 1, "R4");
    expect_reg("R4 disabled no hit", 2'd3, 20'h02);

    // R5 write then read back, R12 gaps on input
    wr_reg(2'd3, 20'h6);
    run_write(20'h00100, 5, 2, 16'hA000);
    expect_reg("R5 end addr", 2'd0, 20'h00105);
    run_read(20'h00100, 5, 2, "R5 readback");

    // R7 write window edges
    wr_reg(2'd2, 20'h40);
    wr_reg(2'd3, 20'h6);
    wr_reg(2'd1, 20'h00225);
    run_write(20'h00200, 5, 1, 16'h1100);
    expect_reg("R7 upper edge hits", 2'd3, 20'h06);
    wr_reg(2'd3, 20'h6);
    wr_reg(2'd1, 20'h00205);
    run_write(20'h00200, 5, 1, 16'h1200);
    expect_reg("R7 end addr no hit", 2'd3, 20'h02);
    wr_reg(2'd3, 20'h6);
    wr_reg(2'd1, 20'h00226);
    run_write(20'h00200, 5, 1, 16'h1300);
    expect_reg("R7 past window no hit", 2'd3, 20'h02);
    wr_reg(2'd3, 20'h6);
    wr_reg(2'd1, 20'h00206);
    run_write(20'h00200, 5, 1, 16'h1400);
    expect_reg("R7 lower edge hits", 2'd3, 20'h06);
    wr_reg(2'd2, 20'h00);
    wr_reg(2'd3, 20'h6);

    // R6 reload threshold
    run_write(20'hFFFFC, 2, 1, 16'h2000);
    expect_reg("R6 end at limit kept", 2'd0, 20'hFFFFE);
    run_write(20'hFFFFC, 3, 1, 16'h2100);
    expect_reg("R6 reload", 2'd0, 20'h02800);
    run_write(20'hFFFFE, 3, 1, 16'h2200);
    expect_reg("R6 crossing reload", 2'd0, 20'h02800);

    // R8 strobe
    wr_reg(2'd2, 20'h70);
    expect_reg("R8 ctrl written", 2'd2, 20'h70);
    expect_reg("R8 ready clear before strobe", 2'd3, 20'h02);
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    expect_reg("R8 ctrl mode cleared", 2'd2, 20'h40);
    expect_reg("R8 ready set", 2'd3, 20'h82);
    wr_reg(2'd2, 20'h00);
    wr_reg(2'd3, 20'h6);

    // R11 zero length ignored
    wr_reg(2'd0, 20'h00777);
    pulse_start(1'b0, 16'd0);
    @(negedge clk);
    check("R11 zero length busy", {35'h0, busy}, 36'h0);
    expect_reg("R11 zero length addr", 2'd0, 20'h00777);
    expect_reg("R11 zero length ready kept", 2'd3, 20'h80);

    // R11 start while busy, with output stalled (R12)
    begin
      int d0;
      wr_reg(2'd0, 20'h00040);
      for (int i = 0; i < 3; i++) exp_rd.push_back(peek(20'h00040 + 20'(i)));
      d0 = done_cnt;
      pulse_start(1'b0, 16'd3);
      repeat (4) @(negedge clk);
      check("R12 held valid", {35'h0, hout_valid}, 36'h1);
      pulse_start(1'b1, 16'd2);
      for (int c = 0; busy; c++) begin
        hout_ready = 1'b1;
        @(negedge clk);
      end
      hout_ready = 1'b0;
      repeat (3) @(negedge clk);
      check("R11 busy start ignored done", 36'(done_cnt - d0), 36'h1);
      check("R11 busy start no words left", 36'(exp_rd.size()), 36'h0);
      expect_reg("R11 busy start addr", 2'd0, 20'h00056);
    end

    finish_run();
  end

endmodule